// File: doc/BRIEF.md
# Line Transmit Rail Formatter

This block is the digital transmit front end of one channel of a DS3, E3 or STS-1 line interface. It takes framer data and produces two pulse-request outputs for an external line driver. One output asks for a positive-polarity mark and the other for a negative-polarity mark. The data comes either as two rails, with separate positive and negative data inputs, or as a single binary rail. Binary data is turned into a bipolar signal by plain alternate mark inversion. Zero substitution is not part of this block.

A five-bit control register is loaded through a write strobe. It picks the rail mode and the sampling clock edge, and it can force an all-ones line pattern or switch the transmitter off. A level-select bit is held in the register and shown on a status pin; it has no effect on the marks. In dual-rail mode the block flags a conflict when both rails carry a 1 in the same bit period.

Top module: `ltx_rail_formatter`

## Requirements
- R1: After reset, both mark outputs, the clash flag and the level status are low. The control register is all zeros, so the block is in dual-rail mode with falling-edge sampling. The first alternating mark after reset is positive.
- R2: In dual-rail mode with invert clear, the inputs are sampled on the falling clock edge. A sampled 1 on the positive input drives the positive mark, and a sampled 1 on the negative input drives the negative mark. The result appears after the next rising edge and lasts one period.
- R3: In dual-rail mode, a period in which both inputs are sampled as 1 gives no mark on either output. It also sets the clash flag, which stays set until reset.
- R4: In single-rail mode (control bit 0 set), a sampled 1 on the positive input gives one mark, with a polarity opposite to the previous alternating mark. A sampled 0 gives no mark.
- R5: In single-rail mode, the negative input has no effect on the marks and never sets the clash flag.
- R6: With control bit 2 set, the inputs are sampled on the rising clock edge instead. The mark appears after the following rising edge, so the delay is one period longer than in R2.
- R7: With control bit 3 set, the input data is replaced by a continuous stream of 1s, with the mark polarity alternating every period. This takes priority over both rail modes.
- R8: With control bit 4 set, both mark outputs are low whatever the other bits are. The polarity state holds and the clash flag is not set.
- R9: Control bit 1 drives the level status output and nothing else.
- R10: A write loads all five control bits on the rising edge at which the write strobe is high. The bit positions are 4 off, 3 all-ones, 2 invert, 1 level, 0 single-rail. The new value governs the mark produced at the next rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Transmit clock at line rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr | input | 1 | Control register write strobe |
| cfg_wdata | input | 5 | Control register write value |
| pos_in | input | 1 | Positive-rail data, or binary data in single-rail mode |
| neg_in | input | 1 | Negative-rail data |
| mark_pos | output | 1 | Positive-polarity pulse request |
| mark_neg | output | 1 | Negative-polarity pulse request |
| level_o | output | 1 | Level-select status |
| clash_err | output | 1 | Sticky dual-rail conflict flag |

## Verification
The bench builds the block with its default parameter, so the first alternating mark after reset is positive. That choice makes the R1 and R4 polarity sequences directly predictable. The random phase writes the control register often, so mode switches land in the middle of mark streams. This exercises the rising-edge path and its extra period of delay, and shows that polarity carries across changes between rail modes. A reset in the middle of the run shows that the sticky clash flag is cleared only by reset.

// File: rtl/ltx_pkg.sv
package ltx_pkg;

    typedef struct packed {
        logic off;
        logic aos;
        logic inv;
        logic lvl;
        logic bin;
    } ltx_cfg_t;

    localparam int CFG_W = $bits(ltx_cfg_t);

    typedef struct packed {
        ltx_cfg_t cfg;
        logic     pol;
        logic     err;
        logic     mp;
        logic     mn;
    } ltx_state_t;

endpackage

// File: rtl/ltx_edge_sampler.sv
module ltx_edge_sampler #(
    parameter int W = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         inv,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    logic [W-1:0] fall_q;
    logic [W-1:0] rise_q;

    for (genvar i = 0; i < W; i++) begin : g_lane
        always_ff @(negedge clk or negedge rst_n) begin
            if (!rst_n) fall_q[i] <= 1'b0;
            else        fall_q[i] <= din[i];
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) rise_q[i] <= 1'b0;
            else        rise_q[i] <= din[i];
        end

        assign dout[i] = inv ? rise_q[i] : fall_q[i];
    end
endmodule

// File: rtl/ltx_mark_encoder.sv
module ltx_mark_encoder
    import ltx_pkg::*;
(
    input  ltx_cfg_t cfg,
    input  logic     dp,
    input  logic     dn,
    input  logic     pol,
    output logic     mp,
    output logic     mn,
    output logic     pol_nxt,
    output logic     clash
);
    logic mark;

    always_comb begin
        mp      = 1'b0;
        mn      = 1'b0;
        pol_nxt = pol;
        clash   = 1'b0;
        mark    = cfg.aos | dp;
        if (!cfg.off) begin
            if (cfg.aos || cfg.bin) begin
                if (mark) begin
                    mp      = !pol;
                    mn      = pol;
                    pol_nxt = !pol;
                end
            end else if (dp && dn) begin
                clash = 1'b1;
            end else begin
                mp = dp;
                mn = dn;
            end
        end
    end
endmodule

// File: rtl/ltx_rail_formatter.sv
module ltx_rail_formatter
    import ltx_pkg::*;
#(
    parameter bit FIRST_NEG = 1'b0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_wr,
    input  logic [CFG_W-1:0] cfg_wdata,
    input  logic             pos_in,
    input  logic             neg_in,
    output logic             mark_pos,
    output logic             mark_neg,
    output logic             level_o,
    output logic             clash_err
);
    localparam int RAILS = 2;

    ltx_state_t       st_d, st_q;
    logic [RAILS-1:0] smp;
    logic             enc_mp, enc_mn, enc_pol, enc_clash;
    ltx_cfg_t         cfg_q;
    logic             pol_q;

    assign cfg_q = st_q.cfg;
    assign pol_q = st_q.pol;

    ltx_edge_sampler #(.W(RAILS)) u_smp (
        .clk  (clk),
        .rst_n(rst_n),
        .inv  (st_q.cfg.inv),
        .din  ({neg_in, pos_in}),
        .dout (smp)
    );

    ltx_mark_encoder u_enc (
        .cfg    (st_q.cfg),
        .dp     (smp[0]),
        .dn     (smp[1]),
        .pol    (st_q.pol),
        .mp     (enc_mp),
        .mn     (enc_mn),
        .pol_nxt(enc_pol),
        .clash  (enc_clash)
    );

    always_comb begin
        st_d     = st_q;
        st_d.mp  = enc_mp;
        st_d.mn  = enc_mn;
        st_d.pol = enc_pol;
        st_d.err = st_q.err | enc_clash;
        if (cfg_wr) st_d.cfg = ltx_cfg_t'(cfg_wdata);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q     <= '0;
            st_q.pol <= FIRST_NEG;
        end else begin
            st_q <= st_d;
        end
    end

    assign mark_pos  = st_q.mp;
    assign mark_neg  = st_q.mn;
    assign level_o   = st_q.cfg.lvl;
    assign clash_err = st_q.err;
endmodule

// File: rtl/ltx_rail_formatter_chk.sv
module ltx_rail_formatter_chk
    import ltx_pkg::*;
(
    input logic     clk,
    input logic     rst_n,
    input ltx_cfg_t cfg_q,
    input logic     pol_q,
    input logic     mark_pos,
    input logic     mark_neg,
    input logic     clash_err
);
    // R8
    off_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_q.off |=> (!mark_pos && !mark_neg));

    // R3
    one_mark_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(mark_pos && mark_neg));

    // R3
    clash_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clash_err |=> clash_err);

    // R7
    all_ones_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_q.aos && !cfg_q.off) |=> (mark_pos ^ mark_neg));

    // R4
    alt_pos_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(cfg_q.aos || cfg_q.bin) && mark_pos) |-> (pol_q != pol_q ^ 1'b1) && pol_q);

    // R4
    alt_neg_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(cfg_q.aos || cfg_q.bin) && mark_neg) |-> !pol_q);

    // R5
    single_no_clash_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_q.bin && !clash_err) |=> !clash_err);
endmodule

bind ltx_rail_formatter ltx_rail_formatter_chk chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .cfg_q    (cfg_q),
    .pol_q    (pol_q),
    .mark_pos (mark_pos),
    .mark_neg (mark_neg),
    .clash_err(clash_err)
);

// File: tb/ltx_rail_formatter_test.sv
module ltx_rail_formatter_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_wr = 1'b0;
    logic [4:0] cfg_wdata = '0;
    logic       pos_in = 1'b0;
    logic       neg_in = 1'b0;
    logic       mark_pos, mark_neg, level_o, clash_err;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    // reference model state
    logic [4:0] m_cfg;
    logic m_pol, e_mp, e_mn, e_err, r_p, r_n, f_p, f_n, sp, sn;
    string e_tag;

    ltx_rail_formatter uut (
        .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata),
        .pos_in(pos_in), .neg_in(neg_in), .mark_pos(mark_pos),
        .mark_neg(mark_neg), .level_o(level_o), .clash_err(clash_err)
    );

    always #10 clk = ~clk;

    task automatic chk(input string tag, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%b expected=%b at %0t", tag, act, exp, $time);
        end
    endtask

    // mode tag of the mark the model predicts: R8 off, R7 all-ones, R4 single, R2/R6 dual
    function automatic string mode_tag(input logic [4:0] c);
        if (c[4]) return "R8";
        if (c[3]) return "R7";
        if (c[0]) return "R4";
        if (c[2]) return "R6";
        return "R2";
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_cfg = '0; m_pol = 1'b0; e_mp = 1'b0; e_mn = 1'b0; e_err = 1'b0;
            r_p = 1'b0; r_n = 1'b0; e_tag = "R1";
        end else begin
            sp = m_cfg[2] ? r_p : f_p;
            sn = m_cfg[2] ? r_n : f_n;
            e_tag = mode_tag(m_cfg);
            e_mp = 1'b0; e_mn = 1'b0;
            if (!m_cfg[4]) begin
                if (m_cfg[3] || m_cfg[0]) begin
                    if (m_cfg[3] || sp) begin
                        if (m_pol) e_mn = 1'b1; else e_mp = 1'b1;
                        m_pol = !m_pol;
                    end
                end else if (sp && sn) begin
                    e_err = 1'b1;
                    e_tag = "R3";
                end else begin
                    e_mp = sp; e_mn = sn;
                end
            end
            r_p = pos_in; r_n = neg_in;
            if (cfg_wr) m_cfg = cfg_wdata;
        end
    end

    always @(negedge clk) begin
        if (rst_n && !done) begin
            chk({e_tag, " pos mark"}, mark_pos, e_mp);
            chk({e_tag, " neg mark"}, mark_neg, e_mn);
            chk("R3 clash flag", clash_err, e_err);
            chk("R9 R10 level status", level_o, m_cfg[1]);
        end
        if (!rst_n) begin f_p = 1'b0; f_n = 1'b0; end
        else begin f_p = pos_in; f_n = neg_in; end
    end

    task automatic step(input logic p, input logic n, input logic wr, input logic [4:0] d);
        @(posedge clk);
        #1;
        pos_in = p; neg_in = n; cfg_wr = wr; cfg_wdata = d;
    endtask

    initial begin
        #3_000_000;
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5eed_0042));
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk); #1;
        // R1 reset state
        chk("R1 pos mark", mark_pos, 1'b0);
        chk("R1 neg mark", mark_neg, 1'b0);
        chk("R1 clash", clash_err, 1'b0);
        chk("R1 level", level_o, 1'b0);
        // R2 dual rail, R3 clash
        step(1, 0, 0, 0); step(0, 1, 0, 0); step(1, 1, 0, 0); step(0, 0, 0, 0);
        // R10 single-rail write, R4 alternate, R5 neg ignored
        step(0, 0, 1, 5'b00001);
        step(1, 1, 0, 0); step(1, 0, 0, 0); step(0, 1, 0, 0); step(1, 1, 0, 0);
        // R7 all ones over single rail, R8 off over all ones
        step(0, 0, 1, 5'b01001); step(0, 0, 0, 0); step(0, 0, 0, 0);
        step(0, 0, 1, 5'b11011); step(1, 0, 0, 0); step(1, 1, 0, 0);
        // R6 rising-edge sampling in dual rail
        step(0, 0, 1, 5'b00100); step(1, 0, 0, 0); step(0, 1, 0, 0); step(0, 0, 0, 0);
        for (int i = 0; i < 4000; i++) begin
            logic wr;
            logic [4:0] d;
            wr = ($urandom % 12) == 0;
            d = 5'($urandom);
            if (($urandom % 4) != 0) d[4] = 1'b0;
            if (($urandom % 3) != 0) d[3] = 1'b0;
            step(1'($urandom), 1'($urandom), wr, d);
            if (i == 2000) begin
                // R3 flag clears only through reset
                #2 rst_n = 1'b0;
                @(negedge clk);
                chk("R3 clash cleared by reset", clash_err, 1'b0);
                step(0, 0, 0, 0);
                rst_n = 1'b1;
            end
        end
        step(0, 0, 0, 0);
        @(negedge clk); #2;
        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule